// File: doc/BRIEF.md
# First-Order Digital Delta-Sigma Modulator

This block turns a stream of signed multi-bit samples into a one-bit stream whose density of ones follows the input level. On every enabled clock it forms the difference between the new sample and the full-scale value selected by the last output bit. It adds that difference into a saturating integrator. It then takes the sign of the updated integrator as the next output bit. The rounding error of each one-bit decision is carried into the next one, so the error does not grow over time and its energy is pushed toward high frequencies.

The block is meant to run at a rate far above the band of interest, for example 500 kHz for a signal band of about 10 Hz. A downstream counter or filter recovers the level from the stream. The input width and the integrator width are parameters. Full scale is the largest positive input code, ±(2^(IN_W-1)-1).

Top module: `dsm_mod`

## Requirements
- R1: A synchronous reset clears the integrator to 0 and the output bit to 0. The first output after reset is 0.
- R2: An output bit of 1 feeds back +FS and an output bit of 0 feeds back -FS, where FS = 2^(IN_W-1)-1 (32767 by default).
- R3: After each enabled clock, the output bit is 1 exactly when the updated integrator is greater than or equal to 0.
- R4: On each enabled clock, the integrator becomes its old value plus (input − feedback of the previous output bit).
- R5: The integrator saturates. A sum above 2^(ACC_W-1)-1 clamps to that value, and a sum below −2^(ACC_W-1) clamps to that value. It never wraps.
- R6: While en is low, the integrator and the output bit hold their values.
- R7: For a constant input x with |x| ≤ FS, applied from reset for N enabled clocks, the count k of ones in the N outputs satisfies |2·FS·k − N·(x+FS)| ≤ 2·FS.
- R8: With input +FS from reset, every output is 1. With input −FS from reset, the first output is 1 and every later output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; the state updates only when high |
| din | input | IN_W | Signed two's-complement input sample |
| dout | output | 1 | One-bit modulator output (1 = +FS, 0 = −FS) |

## Verification
The bench drives the most negative input code, which lies one step beyond full scale. That code makes the integrator drift without limit. A narrow second instance is driven long enough to reach the clamp and is then driven hard the other way. A design that wrapped instead of clamping would flip the sign of the integrator and emit a burst of wrong bits. The bench also applies both full-scale inputs from reset: a threshold placed on the wrong side of zero, or a feedback polarity that is reversed, gives a stream that sticks at the wrong value. Random enable gaps show whether a design lets the state move while disabled. Long constant runs measure the density of ones, which shows any drift from a wrong feedback magnitude.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   // Largest positive code of a signed word of width w: the modulator full scale
   function automatic int full_scale(input int w);
      return (1 << (w - 1)) - 1;
   endfunction
endpackage

// File: rtl/dsm_diff.sv
module dsm_diff #(
   parameter int IN_W = 16
) (
   input  logic                   fb_bit,
   input  logic signed [IN_W-1:0] din,
   output logic signed [IN_W:0]   diff
);
   localparam logic signed [IN_W:0] FS_P = {2'b00, {(IN_W-1){1'b1}}};

   logic signed [IN_W:0] din_x;
   logic signed [IN_W:0] fb_val;

   always_comb begin
      din_x  = {din[IN_W-1], din};
      fb_val = fb_bit ? FS_P : -FS_P;
      diff   = din_x - fb_val;
   end
endmodule

// File: rtl/dsm_integ.sv
module dsm_integ #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 20
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [IN_W:0]    diff,
   output logic signed [ACC_W-1:0] acc_q,
   output logic signed [ACC_W-1:0] acc_nxt
);
   localparam int EXT_W = ACC_W - IN_W;
   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   logic signed [ACC_W:0] sum;
   logic                  ovf;

   always_comb begin
      sum = {acc_q[ACC_W-1], acc_q} + {{EXT_W{diff[IN_W]}}, diff};
      ovf = sum[ACC_W] ^ sum[ACC_W-1];
      if (ovf) acc_nxt = sum[ACC_W] ? ACC_MIN : ACC_MAX;
      else     acc_nxt = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)     acc_q <= '0;
      else if (en) acc_q <= acc_nxt;
   end

   AST_ACC_RESET: assert property (@(posedge clk) rst |=> (acc_q == '0)); // R1
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc_q)); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (en && !acc_q[ACC_W-1] && !diff[IN_W]) |=> ($signed(acc_q) >= $past($signed(acc_q)))); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (en && acc_q[ACC_W-1] && diff[IN_W]) |=> ($signed(acc_q) <= $past($signed(acc_q)))); // R5
endmodule

// File: rtl/dsm_quant.sv
module dsm_quant #(
   parameter int ACC_W = 20
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [ACC_W-1:0] acc_nxt,
   output logic                    bit_q
);
   always_ff @(posedge clk) begin
      if (rst)     bit_q <= 1'b0;
      else if (en) bit_q <= ~acc_nxt[ACC_W-1];
   end

   AST_BIT_RESET: assert property (@(posedge clk) rst |=> !bit_q); // R1
   AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(bit_q)); // R6
endmodule

// File: rtl/dsm_mod.sv
module dsm_mod #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 20
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   en,
   input  logic signed [IN_W-1:0] din,
   output logic                   dout
);
   localparam int FS = dsm_pkg::full_scale(IN_W);

   generate
      if (IN_W < 2) begin : g_bad_in
         $error("dsm_mod: IN_W must be at least 2");
      end
      if (ACC_W < IN_W + 2) begin : g_bad_acc
         $error("dsm_mod: ACC_W must be at least IN_W+2 to hold twice full scale");
      end
   endgenerate

   logic signed [IN_W:0]    diff;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_nxt;
   logic                    bit_q;

   dsm_diff #(.IN_W(IN_W)) u_diff (
      .fb_bit (bit_q),
      .din    (din),
      .diff   (diff)
   );

   dsm_integ #(.IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .diff    (diff),
      .acc_q   (acc_q),
      .acc_nxt (acc_nxt)
   );

   dsm_quant #(.ACC_W(ACC_W)) u_quant (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .acc_nxt (acc_nxt),
      .bit_q   (bit_q)
   );

   assign dout = bit_q;

   AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
      en |=> (dout == !acc_q[ACC_W-1])); // R3
   AST_FB_STEP: assert property (@(posedge clk) disable iff (rst)
      (en && (din == FS[IN_W-1:0]) && dout) |=> ($stable(acc_q) && dout)); // R2
endmodule

// File: tb/tb_dsm_mod.sv
module tb_dsm_mod;
   localparam int FS   = 32767;
   localparam int FS_N = 127;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0;
   logic signed [15:0] din = '0;
   logic signed [7:0]  din_n = '0;
   logic dout, dout_n;

   always #4 clk = ~clk;

   dsm_mod dut (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout));
   dsm_mod #(.IN_W(8), .ACC_W(10)) dut_n (.clk(clk), .rst(rst), .en(en), .din(din_n), .dout(dout_n));

   int n_chk = 0;
   int n_bad = 0;
   longint m_acc = 0, n_acc = 0;
   logic m_bit = 1'b0, n_bit = 1'b0;
   logic p_r = 1'b1, p_e = 1'b0, p_out = 1'b0, last_out = 1'b0;

   function automatic longint nxt(input longint acc, input logic b, input longint x,
                                  input longint fs, input int accw);
      longint s, hi, lo;
      hi = (longint'(1) <<< (accw - 1)) - 1;
      lo = -hi - 1;
      s  = acc + x - (b ? fs : -fs);
      if (s > hi) s = hi;
      if (s < lo) s = lo;
      return s;
   endfunction

   task automatic tick(input logic r, input logic e, input int x, input int xn);
      @(negedge clk);
      n_chk++;
      if (dout !== m_bit) begin
         n_bad++;
         $display("FAIL R2 R3 R4 stream at %0t: got %b expected %b", $time, dout, m_bit);
      end
      n_chk++;
      if (dout_n !== n_bit) begin
         n_bad++;
         $display("FAIL R5 narrow stream at %0t: got %b expected %b", $time, dout_n, n_bit);
      end
      if (!p_r && !p_e) begin
         n_chk++;
         if (dout !== p_out) begin
            n_bad++;
            $display("FAIL R6 hold at %0t: got %b expected %b", $time, dout, p_out);
         end
      end
      last_out = dout;
      p_out = dout;
      rst = r; en = e; din = x[15:0]; din_n = xn[7:0];
      if (r) begin
         m_acc = 0; m_bit = 1'b0; n_acc = 0; n_bit = 1'b0;
      end else if (e) begin
         m_acc = nxt(m_acc, m_bit, x, FS, 20);
         m_bit = (m_acc >= 0);
         n_acc = nxt(n_acc, n_bit, xn, FS_N, 10);
         n_bit = (n_acc >= 0);
      end
      p_r = r; p_e = e;
   endtask

   task automatic run_const(input int x, input int n);
      int ones;
      longint lhs, rhs;
      ones = 0;
      tick(1'b1, 1'b0, x, 0);
      tick(1'b1, 1'b0, x, 0);
      for (int i = 0; i < n; i++) begin
         tick(1'b0, 1'b1, x, 0);
         if (i == 0) begin
            n_chk++;
            if (last_out !== 1'b0) begin
               n_bad++;
               $display("FAIL R1 reset output: got %b expected 0", last_out);
            end
         end else begin
            ones += int'(last_out);
         end
      end
      tick(1'b0, 1'b0, x, 0);
      ones += int'(last_out);
      lhs = 2 * longint'(FS) * ones;
      rhs = longint'(n) * (x + FS);
      n_chk++;
      if ((lhs - rhs > 2 * FS) || (rhs - lhs > 2 * FS)) begin
         n_bad++;
         $display("FAIL R7 density x=%0d: got %0d ones expected about %0d",
                  x, ones, rhs / (2 * FS));
      end
      if (x == FS) begin
         n_chk++;
         if (ones != n) begin
            n_bad++;
            $display("FAIL R8 +FS: got %0d ones expected %0d", ones, n);
         end
      end
      if (x == -FS) begin
         n_chk++;
         if (ones != 1) begin
            n_bad++;
            $display("FAIL R8 -FS: got %0d ones expected 1", ones);
         end
      end
   endtask

   initial begin
      int seed_v, x, xn, sel;
      logic e, r;
      seed_v = int'($urandom(32'h5EED_0042));
      tick(1'b1, 1'b0, 0, 0);
      tick(1'b1, 1'b0, 0, 0);
      n_chk++;
      if (dout !== 1'b0 || dout_n !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset state: got %b/%b expected 0/0", dout, dout_n);
      end
      run_const(0, 2000);
      run_const(FS, 2000);
      run_const(-FS, 2000);
      run_const(12345, 2000);
      run_const(-20000, 2000);
      run_const(1, 3000);
      // R5: drive the narrow instance past its clamp, then reverse
      tick(1'b1, 1'b0, 0, 0);
      for (int i = 0; i < 700; i++) tick(1'b0, 1'b1, -32768, -128);
      for (int i = 0; i < 100; i++) tick(1'b0, 1'b1, 32767, 127);
      for (int i = 0; i < 700; i++) tick(1'b0, 1'b1, -32768, -128);
      for (int i = 0; i < 100; i++) tick(1'b0, 1'b1, 5, 3);
      // Random mix with directed corner codes and enable gaps (R2 R3 R4 R6)
      for (int i = 0; i < 20000; i++) begin
         sel = int'($urandom_range(7));
         case (sel)
            0: begin x = FS;     xn = FS_N; end
            1: begin x = -FS;    xn = -FS_N; end
            2: begin x = -32768; xn = -128; end
            default: begin
               x  = int'($urandom_range(65535)) - 32768;
               xn = int'($urandom_range(255)) - 128;
            end
         endcase
         e = ($urandom_range(3) != 0);
         r = ($urandom_range(499) == 0);
         tick(r, e, x, xn);
      end
      tick(1'b0, 1'b0, 0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule